// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulate Unit

This block multiplies two signed 8-bit operands and adds the product into a 24-bit signed accumulator, so that each accepted pair performs `acc <= acc + B*C`. It can take a new operand pair on every clock and never stalls. The multiply is spread over three registered segments: partial-product formation, carry-save reduction and a final carry-propagate add. A fourth segment adds the product into the accumulator. Data moves between segments only through pipeline registers, and each segment is its own clocked process.

A valid bit and a clear bit are captured together with the operands and travel beside them. The accumulator changes only when one of those two bits reaches the last segment. A clear on its own zeroes the accumulator. A clear that comes with a valid pair loads that pair's product, which starts a new sum. The result-valid output rises in the same cycle that the accumulator takes in a product, four clock edges after the operands were sampled. Arithmetic wraps modulo 2^24 and there is no saturation.

Top module: `pipe_mac`

## Requirements
- R1: While `rst_n` is low and after its release, `acc_out` is 0 and `out_vld` is 0 until a captured valid or clear reaches the last segment.
- R2: An input sampled at rising edge k (with `in_vld`=1) affects `acc_out` and raises `out_vld` right after edge k+3, which is four registered stages. `out_vld` is 1 only in cycles that carry such a product.
- R3: For a valid pair without clear, the new `acc_out` equals the old `acc_out` plus the signed two's-complement product `in_b * in_c`, sign-extended to 24 bits.
- R4: Valid pairs on consecutive cycles each accumulate exactly once, with no stall and no lost or doubled product.
- R5: A cycle with `in_vld`=0 and `in_clr`=0 leaves `acc_out` unchanged at its slot, whatever values `in_b` and `in_c` hold.
- R6: `in_clr`=1 with `in_vld`=0 sets `acc_out` to 0 at the same four-edge latency, and `out_vld` stays 0 for that slot.
- R7: `in_clr`=1 with `in_vld`=1 sets `acc_out` to that pair's product. No earlier sum is added to it.
- R8: The extreme operands give exact products: -128*-128 = 16384, -128*127 = -16256, 127*127 = 16129.
- R9: The accumulator wraps modulo 2^24. Overflow past +8388607 continues from -8388608.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand pair on `in_b`/`in_c` is to be accumulated |
| in_clr | input | 1 | Restart the sum at this slot |
| in_b | input | 8 | Signed multiplicand |
| in_c | input | 8 | Signed multiplier |
| acc_out | output | 24 | Signed accumulator value |
| out_vld | output | 1 | A product was taken into `acc_out` in this cycle |

## Verification
Two situations are hard to reach from the ports. The first is a clear that lands in the last segment together with a valid product. The second is the accumulator crossing the 24-bit signed limit. For the first, the stimulus issues clears both alone and together with operand pairs, mixed into long back-to-back streams, so that both clear cases reach the last segment with pipeline traffic around them. For the second, it feeds several hundred consecutive -128*-128 pairs so the sum rises through +8388607, while a behavioural model with its own delay line predicts every cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;
   // control bits that travel beside the data in every segment
   typedef struct packed {
      logic vld;
      logic clr;
   } mac_tag_t;

   localparam mac_tag_t MAC_TAG_IDLE = '{vld: 1'b0, clr: 1'b0};
endpackage

// File: rtl/mac_pp_stage.sv
// Segment 1: capture operands and form the partial-product rows.
// Rows 0..OP_W-2 are c[i] ? b<<i : 0; the sign row is inverted and
// the final row carries the +1 that completes its negation.
module mac_pp_stage
   import mac_pkg::*;
#(
   parameter int OP_W   = 8,
   parameter int PROD_W = 2 * OP_W,
   parameter int ROWS   = OP_W + 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  mac_tag_t                    tag_i,
   input  logic [OP_W-1:0]             b_i,
   input  logic [OP_W-1:0]             c_i,
   output mac_tag_t                    tag_o,
   output logic [ROWS-1:0][PROD_W-1:0] rows_o
);
   logic [PROD_W-1:0]             b_ext;
   logic [ROWS-1:0][PROD_W-1:0]   rows_d;

   assign b_ext = PROD_W'($signed(b_i));

   for (genvar i = 0; i < OP_W - 1; i++) begin : g_row
      assign rows_d[i] = c_i[i] ? (b_ext << i) : '0;
   end

   assign rows_d[OP_W-1] = c_i[OP_W-1] ? ~(b_ext << (OP_W - 1)) : '0;
   assign rows_d[OP_W]   = {{(PROD_W-1){1'b0}}, c_i[OP_W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_o  <= MAC_TAG_IDLE;
         rows_o <= '0;
      end else begin
         tag_o  <= tag_i;
         rows_o <= rows_d;
      end
   end
endmodule

// File: rtl/mac_csa_stage.sv
// Segment 2: linear chain of carry-save adders, ROWS rows down to two.
module mac_csa_stage
   import mac_pkg::*;
#(
   parameter int ROWS = 9,
   parameter int W    = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  mac_tag_t              tag_i,
   input  logic [ROWS-1:0][W-1:0] rows_i,
   output mac_tag_t              tag_o,
   output logic [W-1:0]          sum_o,
   output logic [W-1:0]          cry_o
);
   localparam int LVLS = ROWS - 1;

   logic [LVLS-1:0][W-1:0] s_w;
   logic [LVLS-1:0][W-1:0] k_w;

   assign s_w[0] = rows_i[0];
   assign k_w[0] = rows_i[1];

   for (genvar l = 1; l < LVLS; l++) begin : g_lvl
      logic [W-1:0] x, y, z;
      assign x      = s_w[l-1];
      assign y      = k_w[l-1];
      assign z      = rows_i[l+1];
      assign s_w[l] = x ^ y ^ z;
      assign k_w[l] = ((x & y) | (x & z) | (y & z)) << 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_o <= MAC_TAG_IDLE;
         sum_o <= '0;
         cry_o <= '0;
      end else begin
         tag_o <= tag_i;
         sum_o <= s_w[LVLS-1];
         cry_o <= k_w[LVLS-1];
      end
   end
endmodule

// File: rtl/mac_cpa_stage.sv
// Segment 3: carry-propagate add of the two carry-save vectors.
// CPA_STYLE 0 uses the operator; 1 builds a generate/propagate chain.
module mac_cpa_stage
   import mac_pkg::*;
#(
   parameter int W         = 16,
   parameter int CPA_STYLE = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  mac_tag_t     tag_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output mac_tag_t     tag_o,
   output logic [W-1:0] prod_o
);
   logic [W-1:0] sum_d;

   if (CPA_STYLE == 0) begin : g_op
      assign sum_d = a_i + b_i;
   end else begin : g_chain
      logic [W-1:0] cy;
      assign cy[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum_d[i] = a_i[i] ^ b_i[i] ^ cy[i];
         if (i < W - 1) begin : g_c
            assign cy[i+1] = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & cy[i]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_o  <= MAC_TAG_IDLE;
         prod_o <= '0;
      end else begin
         tag_o  <= tag_i;
         prod_o <= sum_d;
      end
   end
endmodule

// File: rtl/mac_acc_stage.sv
// Segment 4: accumulator; feedback stays inside this one register.
module mac_acc_stage
   import mac_pkg::*;
#(
   parameter int PROD_W = 16,
   parameter int ACC_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mac_tag_t          tag_i,
   input  logic [PROD_W-1:0] prod_i,
   output logic [ACC_W-1:0]  acc_o,
   output logic              vld_o
);
   logic [ACC_W-1:0] prod_x;

   assign prod_x = ACC_W'($signed(prod_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= tag_i.vld;
         if (tag_i.clr) begin
            acc_o <= tag_i.vld ? prod_x : '0;
         end else if (tag_i.vld) begin
            acc_o <= acc_o + prod_x;
         end
      end
   end
endmodule

// File: rtl/pipe_mac.sv
module pipe_mac
   import mac_pkg::*;
#(
   parameter int OP_W      = 8,
   parameter int ACC_W     = 24,
   parameter int CPA_STYLE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic             in_clr,
   input  logic [OP_W-1:0]  in_b,
   input  logic [OP_W-1:0]  in_c,
   output logic [ACC_W-1:0] acc_out,
   output logic             out_vld
);
   localparam int PROD_W = 2 * OP_W;
   localparam int ROWS   = OP_W + 1;

   if (OP_W < 2) begin : g_bad_op
      $error("pipe_mac: OP_W must be at least 2");
   end
   if (ACC_W < PROD_W) begin : g_bad_acc
      $error("pipe_mac: ACC_W must hold a full product");
   end
   if (CPA_STYLE < 0 || CPA_STYLE > 1) begin : g_bad_cpa
      $error("pipe_mac: CPA_STYLE must be 0 or 1");
   end

   mac_tag_t                    tag_in, tag1, tag2, tag3;
   logic [ROWS-1:0][PROD_W-1:0] rows1;
   logic [PROD_W-1:0]           sum2, cry2, prod3;

   assign tag_in = '{vld: in_vld, clr: in_clr};

   mac_pp_stage #(.OP_W(OP_W), .PROD_W(PROD_W), .ROWS(ROWS)) u_pp (
      .clk(clk), .rst_n(rst_n), .tag_i(tag_in), .b_i(in_b), .c_i(in_c),
      .tag_o(tag1), .rows_o(rows1)
   );

   mac_csa_stage #(.ROWS(ROWS), .W(PROD_W)) u_csa (
      .clk(clk), .rst_n(rst_n), .tag_i(tag1), .rows_i(rows1),
      .tag_o(tag2), .sum_o(sum2), .cry_o(cry2)
   );

   mac_cpa_stage #(.W(PROD_W), .CPA_STYLE(CPA_STYLE)) u_cpa (
      .clk(clk), .rst_n(rst_n), .tag_i(tag2), .a_i(sum2), .b_i(cry2),
      .tag_o(tag3), .prod_o(prod3)
   );

   mac_acc_stage #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .tag_i(tag3), .prod_i(prod3),
      .acc_o(acc_out), .vld_o(out_vld)
   );
endmodule

// File: rtl/pipe_mac_chk.sv
module pipe_mac_chk #(
   parameter int OP_W  = 8,
   parameter int ACC_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_vld,
   input logic             in_clr,
   input logic [OP_W-1:0]  in_b,
   input logic [OP_W-1:0]  in_c,
   input logic [ACC_W-1:0] acc_out,
   input logic             out_vld
);
   logic [3:0]            v_d, c_d;
   logic [3:0][OP_W-1:0]  b_d, m_d;
   logic                  up;
   logic signed [2*OP_W-1:0] prod_d;
   logic [ACC_W-1:0]      prod_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_d <= '0; c_d <= '0; b_d <= '0; m_d <= '0; up <= 1'b0;
      end else begin
         v_d <= {v_d[2:0], in_vld};
         c_d <= {c_d[2:0], in_clr};
         b_d <= {b_d[2:0], in_b};
         m_d <= {m_d[2:0], in_c};
         up  <= 1'b1;
      end
   end

   assign prod_d = $signed(b_d[3]) * $signed(m_d[3]);
   assign prod_x = ACC_W'(prod_d);

   // R2
   vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == v_d[3]);

   // R3
   acc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up && out_vld && !c_d[3]) |-> acc_out == $past(acc_out) + prod_x);

   // R5
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !out_vld && !c_d[3]) |-> $stable(acc_out));

   // R6
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_d[3] && !out_vld) |-> acc_out == '0);

   // R7
   clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_d[3] && out_vld) |-> acc_out == prod_x);
endmodule

bind pipe_mac pipe_mac_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_clr(in_clr),
   .in_b(in_b), .in_c(in_c), .acc_out(acc_out), .out_vld(out_vld)
);

// File: tb/tb_pipe_mac.sv
`timescale 1ns/1ps
module tb_pipe_mac;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0, in_clr = 1'b0;
   logic [7:0]  in_b = '0, in_c = '0;
   logic [23:0] acc_out;
   logic        out_vld;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   string tag = "R1";

   // model: three in-flight slots, then the accumulator
   bit          mv[3];
   bit          mc[3];
   int          mp[3];
   logic [23:0] macc = '0;
   bit          mvld = 1'b0;

   always #2 clk = ~clk;

   pipe_mac dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_clr(in_clr),
      .in_b(in_b), .in_c(in_c), .acc_out(acc_out), .out_vld(out_vld)
   );

   task automatic check_out();
      checks++;
      if (acc_out !== macc || out_vld !== mvld) begin
         fails++;
         $display("FAIL %s: acc=%0d vld=%0b expected acc=%0d vld=%0b",
                  tag, $signed(acc_out), out_vld, $signed(macc), mvld);
      end
   endtask

   task automatic step(input bit v, input bit c,
                       input logic signed [7:0] b, input logic signed [7:0] m);
      in_vld = v; in_clr = c; in_b = b; in_c = m;
      @(posedge clk);
      if (mc[2] && mv[2])  macc = 24'(mp[2]);
      else if (mc[2])      macc = '0;
      else if (mv[2])      macc = 24'(int'($signed(macc)) + mp[2]);
      mvld = mv[2];
      for (int i = 2; i > 0; i--) begin
         mv[i] = mv[i-1]; mc[i] = mc[i-1]; mp[i] = mp[i-1];
      end
      mv[0] = v; mc[0] = c; mp[0] = int'(b) * int'(m);
      @(negedge clk);
      check_out();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'sd0, 8'sd0);
   endtask

   initial begin
      for (int i = 0; i < 3; i++) begin mv[i] = 0; mc[i] = 0; mp[i] = 0; end
      repeat (3) @(negedge clk);
      tag = "R1";
      check_out();
      rst_n = 1'b1;
      idle(3);

      tag = "R2";                       // single pair, watch the slot
      step(1'b1, 1'b0, 8'sd3, 8'sd5);
      idle(5);

      tag = "R4";                       // back-to-back stream
      for (int i = 0; i < 24; i++)
         step(1'b1, 1'b0, 8'($urandom), 8'($urandom));
      idle(4);

      tag = "R5";                       // operands present, not valid
      for (int i = 0; i < 8; i++)
         step(1'b0, 1'b0, 8'sd77, -8'sd9);
      idle(4);

      tag = "R6";                       // clear alone, then mid-stream
      step(1'b0, 1'b1, 8'sd50, 8'sd50);
      idle(4);
      step(1'b1, 1'b0, 8'sd10, 8'sd10);
      step(1'b0, 1'b1, 8'sd0, 8'sd0);
      step(1'b1, 1'b0, -8'sd4, 8'sd6);
      idle(4);

      tag = "R7";                       // clear with a valid pair
      step(1'b1, 1'b0, 8'sd100, 8'sd100);
      step(1'b1, 1'b1, -8'sd7, 8'sd11);
      step(1'b1, 1'b0, 8'sd2, 8'sd2);
      idle(4);

      tag = "R8";                       // extreme operands
      step(1'b1, 1'b1, -8'sd128, -8'sd128);
      step(1'b1, 1'b1, -8'sd128, 8'sd127);
      step(1'b1, 1'b1, 8'sd127, 8'sd127);
      step(1'b1, 1'b1, 8'sd127, -8'sd128);
      step(1'b1, 1'b1, 8'sd0, -8'sd128);
      idle(4);

      tag = "R9";                       // push past +8388607
      step(1'b0, 1'b1, 8'sd0, 8'sd0);
      for (int i = 0; i < 600; i++)
         step(1'b1, 1'b0, -8'sd128, -8'sd128);
      idle(4);

      tag = "R3";                       // random mix with gaps and clears
      for (int i = 0; i < 2000; i++) begin
         int r = int'($urandom_range(0, 15));
         step(r < 11, r == 15 || r == 14, 8'($urandom), 8'($urandom));
      end
      idle(5);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule